// File: doc/BRIEF.md
# Dual-Port Word Memory with Cross-Port Mailbox Interrupts

This block is a synchronous true dual-port static memory. It has two independent ports, called left and right. Each port has its own chip enable, output enable, read/write strobe, address, write data and registered read data. Either port may reach any word in any cycle. The two ports may access the array in the same cycle, including the same word.

The two highest word addresses act as mailboxes. The top word belongs to the left side and the word below it belongs to the right side. When the opposite port writes a side's mailbox, that side's active-low interrupt goes low. The owning side reads its mailbox to take the message, and the read releases the interrupt. A producer on one port can therefore hand a buffer descriptor, such as a ping-pong buffer selector, to a consumer on the other port without polling.

The depth is 2^AW words of DW bits. AW=14 gives the full 16384-word array, with mailboxes at 0x3FFF (left) and 0x3FFE (right). The default AW=10 keeps elaboration small and places the mailboxes at 0x3FF and 0x3FE.

Top module: `dpram_mbox`

## Requirements
- R1: While rst_n is low and after it rises, both interrupt outputs are high and both read data outputs are zero.
- R2: A port write takes place when ce_n=0 and rw_n=0, whatever oe_n is. A port read takes place when ce_n=0, rw_n=1 and oe_n=0. Read data appears on that port's rdata one clock after the edge that samples the address, and it is held until the next read.
- R3: Both ports can access different words in the same cycle. A word written through one port reads back through the other.
- R4: When both ports write the same word in the same cycle, the left port's data is stored.
- R5: A read in the same cycle as a write to the same word by the other port returns the value stored before that cycle.
- R6: A left-port write to the right mailbox (address 2^AW-2) drives r_int_n low one clock later. A right-port read of that address drives r_int_n high one clock later.
- R7: A right-port write to the left mailbox (address 2^AW-1) drives l_int_n low one clock later. A left-port read of that address drives l_int_n high one clock later.
- R8: A pending interrupt stays low through further writes to the mailbox and through idle cycles. If the clearing read and a new setting write happen in the same cycle, the interrupt stays low, and the read returns the older message.
- R9: A cycle with ce_n=1, or a read cycle with oe_n=1, changes no memory word, leaves rdata unchanged and does not clear an interrupt.
- R10: A port writing its own mailbox raises no interrupt. A port reading the other side's mailbox does not clear that side's interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low; required for a read |
| l_rw_n | input | 1 | Left direction: 1 = read, 0 = write |
| l_addr | input | AW | Left word address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left registered read data |
| l_int_n | output | 1 | Left mailbox interrupt, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low; required for a read |
| r_rw_n | input | 1 | Right direction: 1 = read, 0 = write |
| r_addr | input | AW | Right word address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right registered read data |
| r_int_n | output | 1 | Right mailbox interrupt, active low |

## Verification
Every result of this block is due exactly one clock after the edge that samples the access: read data, interrupt assertion and interrupt release alike. The bench drives both ports just after a falling edge and lets one rising edge capture them. It then samples every output at the next falling edge, so each check sees the state left by exactly one access cycle. Cases meant to show no effect are checked the same way, one cycle later, against the value held before the cycle: held read data, an unchanged stored word or an interrupt level that stays put.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Decoded request of one port for one cycle
    typedef struct packed {
        logic rd;       // qualified read
        logic wr;       // qualified write
        logic mb_own;   // address hits this side's mailbox
        logic mb_peer;  // address hits the opposite side's mailbox
    } port_req_t;

endpackage

// File: rtl/dpram_port_decode.sv
module dpram_port_decode
    import dpram_pkg::*;
#(
    parameter int AW      = 10,
    parameter int OWN_MB  = 0,
    parameter int PEER_MB = 1
) (
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          rw_n,
    input  logic [AW-1:0] addr,
    output port_req_t     req
);

    localparam logic [AW-1:0] OWN_A  = AW'(OWN_MB);
    localparam logic [AW-1:0] PEER_A = AW'(PEER_MB);

    always_comb begin
        req         = '0;
        req.wr      = !ce_n && !rw_n;
        req.rd      = !ce_n && rw_n && !oe_n;
        req.mb_own  = (addr == OWN_A);
        req.mb_peer = (addr == PEER_A);
    end

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_wr,
    input  logic          a_rd,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_wr,
    input  logic          b_rd,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);

    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } rd_t;

    logic [DW-1:0] mem [DEPTH];
    rd_t           rd_d, rd_q;

    // Port a has priority: its assignment is issued last.
    always_ff @(posedge clk) begin
        if (b_wr) begin
            mem[b_addr] <= b_wdata;
        end
        if (a_wr) begin
            mem[a_addr] <= a_wdata;
        end
    end

    // Reads sample the array before this edge's writes land.
    always_comb begin
        rd_d = rd_q;
        if (a_rd) begin
            rd_d.a = mem[a_addr];
        end
        if (b_rd) begin
            rd_d.b = mem[b_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign a_rdata = rd_q.a;
    assign b_rdata = rd_q.b;

endmodule

// File: rtl/dpram_mbox_flags.sv
module dpram_mbox_flags
    import dpram_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  port_req_t l_req,
    input  port_req_t r_req,
    output logic      l_int_n,
    output logic      r_int_n
);

    typedef struct packed {
        logic l_pend;
        logic r_pend;
    } flag_t;

    flag_t flag_d, flag_q;

    always_comb begin
        logic l_set, l_clr, r_set, r_clr;
        l_set = r_req.wr && r_req.mb_peer;
        l_clr = l_req.rd && l_req.mb_own;
        r_set = l_req.wr && l_req.mb_peer;
        r_clr = r_req.rd && r_req.mb_own;
        // A fresh message outranks the read that retires the old one.
        flag_d.l_pend = l_set || (flag_q.l_pend && !l_clr);
        flag_d.r_pend = r_set || (flag_q.r_pend && !r_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign l_int_n = !flag_q.l_pend;
    assign r_int_n = !flag_q.r_pend;

endmodule

// File: rtl/dpram_mbox.sv
module dpram_mbox
    import dpram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_ce_n,
    input  logic          l_oe_n,
    input  logic          l_rw_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_int_n,
    input  logic          r_ce_n,
    input  logic          r_oe_n,
    input  logic          r_rw_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_int_n
);

    localparam int LMB = (1 << AW) - 1;
    localparam int RMB = (1 << AW) - 2;

    port_req_t l_req, r_req;

    dpram_port_decode #(.AW(AW), .OWN_MB(LMB), .PEER_MB(RMB)) u_l_dec (
        .ce_n (l_ce_n),
        .oe_n (l_oe_n),
        .rw_n (l_rw_n),
        .addr (l_addr),
        .req  (l_req)
    );

    dpram_port_decode #(.AW(AW), .OWN_MB(RMB), .PEER_MB(LMB)) u_r_dec (
        .ce_n (r_ce_n),
        .oe_n (r_oe_n),
        .rw_n (r_rw_n),
        .addr (r_addr),
        .req  (r_req)
    );

    dpram_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_wr    (l_req.wr),
        .a_rd    (l_req.rd),
        .a_addr  (l_addr),
        .a_wdata (l_wdata),
        .a_rdata (l_rdata),
        .b_wr    (r_req.wr),
        .b_rd    (r_req.rd),
        .b_addr  (r_addr),
        .b_wdata (r_wdata),
        .b_rdata (r_rdata)
    );

    dpram_mbox_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_req   (l_req),
        .r_req   (r_req),
        .l_int_n (l_int_n),
        .r_int_n (r_int_n)
    );

endmodule

// File: rtl/dpram_mbox_chk.sv
module dpram_mbox_chk #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l_ce_n,
    input logic          l_oe_n,
    input logic          l_rw_n,
    input logic [AW-1:0] l_addr,
    input logic [DW-1:0] l_rdata,
    input logic          l_int_n,
    input logic          r_ce_n,
    input logic          r_oe_n,
    input logic          r_rw_n,
    input logic [AW-1:0] r_addr,
    input logic [DW-1:0] r_rdata,
    input logic          r_int_n
);

    localparam logic [AW-1:0] LMB = AW'((1 << AW) - 1);
    localparam logic [AW-1:0] RMB = AW'((1 << AW) - 2);

    logic l_rd, l_wr, r_rd, r_wr;
    assign l_rd = !l_ce_n && l_rw_n && !l_oe_n;
    assign l_wr = !l_ce_n && !l_rw_n;
    assign r_rd = !r_ce_n && r_rw_n && !r_oe_n;
    assign r_wr = !r_ce_n && !r_rw_n;

    // R6
    r_int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && l_addr == RMB) |=> !r_int_n);

    // R6
    r_int_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rd && r_addr == RMB && !(l_wr && l_addr == RMB)) |=> r_int_n);

    // R7
    l_int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_wr && r_addr == LMB) |=> !l_int_n);

    // R7
    l_int_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rd && l_addr == LMB && !(r_wr && r_addr == LMB)) |=> l_int_n);

    // R8
    r_int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_int_n && !(r_rd && r_addr == RMB)) |=> !r_int_n);

    // R8
    l_int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_int_n && !(l_rd && l_addr == LMB)) |=> !l_int_n);

    // R9
    l_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd |=> $stable(l_rdata));

    // R9
    r_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd |=> $stable(r_rdata));

endmodule

bind dpram_mbox dpram_mbox_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_ce_n  (l_ce_n),
    .l_oe_n  (l_oe_n),
    .l_rw_n  (l_rw_n),
    .l_addr  (l_addr),
    .l_rdata (l_rdata),
    .l_int_n (l_int_n),
    .r_ce_n  (r_ce_n),
    .r_oe_n  (r_oe_n),
    .r_rw_n  (r_rw_n),
    .r_addr  (r_addr),
    .r_rdata (r_rdata),
    .r_int_n (r_int_n)
);

// File: tb/sim_dpram_mbox.sv
`timescale 1ns/1ps
module sim_dpram_mbox;

    localparam int AW = 10;
    localparam int DW = 16;
    localparam logic [AW-1:0] LMB = 10'h3FF;
    localparam logic [AW-1:0] RMB = 10'h3FE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_ce_n = 1'b1, l_oe_n = 1'b1, l_rw_n = 1'b1;
    logic [AW-1:0] l_addr = '0;
    logic [DW-1:0] l_wdata = '0;
    logic [DW-1:0] l_rdata;
    logic          l_int_n;
    logic          r_ce_n = 1'b1, r_oe_n = 1'b1, r_rw_n = 1'b1;
    logic [AW-1:0] r_addr = '0;
    logic [DW-1:0] r_wdata = '0;
    logic [DW-1:0] r_rdata;
    logic          r_int_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dpram_mbox #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_rw_n(l_rw_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_int_n(l_int_n),
        .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_rw_n(r_rw_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_int_n(r_int_n)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Port drive helpers: op 0 idle, 1 write, 2 read, 3 read with oe_n high
    task automatic set_l(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_ce_n = (op == 0); l_rw_n = (op != 1); l_oe_n = (op != 2);
        l_addr = a; l_wdata = d;
    endtask

    task automatic set_r(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_ce_n = (op == 0); r_rw_n = (op != 1); r_oe_n = (op != 2);
        r_addr = a; r_wdata = d;
    endtask

    // One access cycle: capture on the rising edge, return at the falling edge
    task automatic step();
        @(negedge clk);
        set_l(0, '0, '0);
        set_r(0, '0, '0);
    endtask

    task automatic t_reset();
        chk("R1 l_int_n in reset", {15'd0, l_int_n}, 16'd1);
        chk("R1 r_int_n in reset", {15'd0, r_int_n}, 16'd1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 l_rdata after reset", l_rdata, 16'h0000);
        chk("R1 r_rdata after reset", r_rdata, 16'h0000);
        chk("R1 l_int_n after reset", {15'd0, l_int_n}, 16'd1);
        chk("R1 r_int_n after reset", {15'd0, r_int_n}, 16'd1);
    endtask

    task automatic t_basic();
        set_l(1, 10'h005, 16'h1234); step();
        chk("R2 no read data from write cycle", l_rdata, 16'h0000);
        set_l(2, 10'h005, '0); step();
        chk("R2 left read after write", l_rdata, 16'h1234);
        set_r(1, 10'h009, 16'hA5A5); step();
        set_r(2, 10'h009, '0); step();
        chk("R2 right read after write", r_rdata, 16'hA5A5);
        step();
        chk("R2 read data held", r_rdata, 16'hA5A5);
    endtask

    task automatic t_cross();
        set_l(1, 10'h010, 16'h0A0A); set_r(1, 10'h020, 16'h0B0B); step();
        set_l(2, 10'h020, '0); set_r(2, 10'h010, '0); step();
        chk("R3 left reads right-written word", l_rdata, 16'h0B0B);
        chk("R3 right reads left-written word", r_rdata, 16'h0A0A);
    endtask

    task automatic t_collide();
        set_l(1, 10'h030, 16'h1111); set_r(1, 10'h030, 16'h2222); step();
        set_l(2, 10'h030, '0); set_r(2, 10'h030, '0); step();
        chk("R4 left wins (left view)", l_rdata, 16'h1111);
        chk("R4 left wins (right view)", r_rdata, 16'h1111);
    endtask

    task automatic t_rbw();
        set_l(1, 10'h040, 16'h3333); step();
        set_l(2, 10'h040, '0); set_r(1, 10'h040, 16'h4444); step();
        chk("R5 read returns old word", l_rdata, 16'h3333);
        set_l(2, 10'h040, '0); step();
        chk("R5 new word visible next read", l_rdata, 16'h4444);
    endtask

    task automatic t_rmb();
        set_l(1, RMB, 16'hBEEF); step();
        chk("R6 r_int_n low after left write", {15'd0, r_int_n}, 16'd0);
        chk("R6 l_int_n untouched", {15'd0, l_int_n}, 16'd1);
        set_r(2, RMB, '0); step();
        chk("R6 right reads message", r_rdata, 16'hBEEF);
        chk("R6 r_int_n released by read", {15'd0, r_int_n}, 16'd1);
    endtask

    task automatic t_lmb();
        set_r(1, LMB, 16'hCAFE); step();
        chk("R7 l_int_n low after right write", {15'd0, l_int_n}, 16'd0);
        chk("R7 r_int_n untouched", {15'd0, r_int_n}, 16'd1);
        set_l(2, LMB, '0); step();
        chk("R7 left reads message", l_rdata, 16'hCAFE);
        chk("R7 l_int_n released by read", {15'd0, l_int_n}, 16'd1);
    endtask

    task automatic t_sticky();
        set_l(1, RMB, 16'h0001); step();
        set_l(1, RMB, 16'h0002); step();
        chk("R8 stays low on second write", {15'd0, r_int_n}, 16'd0);
        step(); step();
        chk("R8 stays low while idle", {15'd0, r_int_n}, 16'd0);
        set_l(1, RMB, 16'h0003); set_r(2, RMB, '0); step();
        chk("R8 read returns older message", r_rdata, 16'h0002);
        chk("R8 set beats clear", {15'd0, r_int_n}, 16'd0);
        set_r(2, RMB, '0); step();
        chk("R8 newest message", r_rdata, 16'h0003);
        chk("R8 released after final read", {15'd0, r_int_n}, 16'd1);
    endtask

    task automatic t_inhibit();
        logic [DW-1:0] held;
        // write with ce_n high
        l_ce_n = 1'b1; l_rw_n = 1'b0; l_oe_n = 1'b1; l_addr = 10'h005; l_wdata = 16'hFFFF;
        step();
        set_l(2, 10'h005, '0); step();
        chk("R9 deselected write ignored", l_rdata, 16'h1234);
        set_l(1, RMB, 16'h0777); step();
        held = r_rdata;
        set_r(3, RMB, '0); step();
        chk("R9 oe_n high read keeps rdata", r_rdata, held);
        chk("R9 oe_n high read keeps interrupt", {15'd0, r_int_n}, 16'd0);
        set_r(2, RMB, '0); step();
        chk("R9 normal read then clears", {15'd0, r_int_n}, 16'd1);
    endtask

    task automatic t_own();
        set_l(1, LMB, 16'h5555); set_r(1, RMB, 16'h6666); step();
        chk("R10 left own-mailbox write no l_int", {15'd0, l_int_n}, 16'd1);
        chk("R10 right own-mailbox write no r_int", {15'd0, r_int_n}, 16'd1);
        set_l(1, RMB, 16'h7777); step();
        set_l(2, RMB, '0); step();
        chk("R10 left reads right mailbox data", l_rdata, 16'h7777);
        chk("R10 foreign read does not clear", {15'd0, r_int_n}, 16'd0);
        set_r(2, RMB, '0); step();
        chk("R10 owner read clears", {15'd0, r_int_n}, 16'd1);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        t_basic();
        t_cross();
        t_collide();
        t_rbw();
        t_rmb();
        t_lmb();
        t_sticky();
        t_inhibit();
        t_own();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule